// File: doc/BRIEF.md
# T1 Receive Line Event Monitor

This block watches a received T1 bipolar line and keeps a six-bit register of sticky event flags for a host. The line arrives as two pulse rails, positive and negative, with a one-cycle bit strobe for each bit period. An external framer supplies a strobe for each framing bit, an error flag for that bit, and a strobe that marks a completed resync together with a flag saying whether the alignment moved.

The monitor finds runs of zeros on the line, framing bits received in error, a dense cluster of framing errors, B8ZS substitution codewords and alignment changes. Each of these sets its own flag. A flag stays set until the host writes a one to it. The register is read at any time on a plain read port. No interrupt is ever raised.

The block does not decode the line. It recognises the substitution codeword whether or not the downstream decoder is using B8ZS, so software can use the flag to choose the line code.

Top module: `t1_line_event_mon`

## Requirements
- R1: After reset every event flag is 0 and `rd_data` reads 6'h00.
- R2: The flag positions in `rd_data`/`wr_data` are: bit 5 alignment change, bit 4 eight-zero run, bit 3 sixteen-zero run, bit 2 severe framing errors, bit 1 B8ZS codeword, bit 0 framing bit error. A cycle with `wr_en` high clears each flag whose `wr_data` bit is 1 and leaves the flags whose bit is 0 unchanged.
- R3: A flag set by an event stays set until it is cleared by the host. Inputs sampled at a clock edge show up in `rd_data` right after that edge.
- R4: A bit is a zero when `bit_en` is high and both rails are low. The eight-zero flag sets when a run reaches eight zeros. A run of seven zeros does not set it.
- R5: The sixteen-zero flag sets when a run reaches sixteen zeros. A run of fifteen zeros does not set it.
- R6: Each zero-run flag sets at most once per run. After a host clear in the middle of a long run, the flag stays clear until a mark has ended the run and a new run reaches the threshold.
- R7: On each `frm_bit_en` strobe, the severe-framing flag sets when at least 2 of the six most recent framing bits (this one included) carried `frm_err`. Two errored framing bits with five good ones between them do not set it.
- R8: The B8ZS flag sets when the eight most recent bits, oldest first, are 0,0,0,V,B,0,V,B. Here V repeats the polarity of the mark just before the pattern, and B has the opposite polarity from the mark before it. Positive means `rx_pos` is high. A bit with both rails high counts as positive. Before the first mark after reset, the reference polarity is negative. A pattern whose polarities alternate normally does not set the flag.
- R9: Every framing bit strobed with `frm_err` high sets the framing-bit-error flag. A framing bit strobed without `frm_err` does not set it.
- R10: `resync_done` with `resync_moved` high sets the alignment-change flag. `resync_done` with `resync_moved` low does not.
- R11: When an event and a host clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per received bit period |
| rx_pos | input | 1 | Positive pulse rail for the current bit |
| rx_neg | input | 1 | Negative pulse rail for the current bit |
| frm_bit_en | input | 1 | Strobe for a framing bit (Ft or FPS) from the framer |
| frm_err | input | 1 | The strobed framing bit was in error |
| resync_done | input | 1 | Framer finished a resync |
| resync_moved | input | 1 | The finished resync changed frame or multiframe alignment |
| wr_en | input | 1 | Host write strobe for clearing flags |
| wr_data | input | 6 | Write-one-to-clear mask |
| rd_data | output | 6 | Current event flags |

## Verification
On every cycle, the embedded assertions check three things. A flag never drops unless the host cleared it. A framing error, a moved resync, or a clear that collides with an event always leaves its flag set. The zero-run flags never rise in a cycle without a bit strobe. Only the bench scenarios can show the run-length thresholds and the once-per-run behaviour. The same holds for the sliding 2-of-6 window edges and the polarity reasoning behind codeword recognition. For these, a reference model follows a random line stream with injected codewords and violations and compares the register after every cycle.

// File: rtl/t1_line_event_mon.sv
module t1_line_event_mon #(
  parameter int SHORT_RUN = 8,
  parameter int LONG_RUN  = 16,
  parameter int FRM_WIN   = 6,
  parameter int FRM_LIMIT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       rx_pos,
  input  logic       rx_neg,
  input  logic       frm_bit_en,
  input  logic       frm_err,
  input  logic       resync_done,
  input  logic       resync_moved,
  input  logic       wr_en,
  input  logic [5:0] wr_data,
  output logic [5:0] rd_data
);
  localparam int CW = $clog2(LONG_RUN + 1);
  localparam int FCW = $clog2(FRM_WIN + 1);

  logic [5:0]         ev;
  logic [CW-1:0]      run_cnt;
  logic [7:0][1:0]    hist;
  logic               pol_ref;
  logic [FRM_WIN-1:0] fwin;

  // zero-run detection
  wire bit_zero = bit_en && !rx_pos && !rx_neg;
  wire run_inc  = bit_zero && (run_cnt != CW'(LONG_RUN));
  wire hit8     = run_inc && (run_cnt == CW'(SHORT_RUN - 1));
  wire hit16    = run_inc && (run_cnt == CW'(LONG_RUN - 1));

  // codeword window: symbol 2'b10 positive, 2'b01 negative, 2'b00 zero
  wire [1:0]       sym_new = {rx_pos, rx_neg & ~rx_pos};
  wire [7:0][1:0]  win_nxt = {sym_new, hist[7:1]};
  wire             pol_nxt = (hist[0] != 2'b00) ? hist[0][1] : pol_ref;
  wire [1:0]       ps      = pol_nxt ? 2'b10 : 2'b01;
  wire [1:0]       ns      = ~ps;
  wire b8_hit = bit_en && (win_nxt == {ps, ns, 2'b00, ns, ps, 2'b00, 2'b00, 2'b00});

  // framing-error window
  wire [FRM_WIN-1:0] fwin_nxt = {fwin[FRM_WIN-2:0], frm_err};
  wire [FCW-1:0]     ferr_cnt = FCW'($countones(fwin_nxt));
  wire sev_hit = frm_bit_en && (ferr_cnt >= FCW'(FRM_LIMIT));
  wire fbe_hit = frm_bit_en && frm_err;

  wire cofa_hit = resync_done && resync_moved;
  wire [5:0] set = {cofa_hit, hit8, hit16, sev_hit, b8_hit, fbe_hit};
  wire [5:0] clr = wr_en ? wr_data : 6'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev      <= '0;
      run_cnt <= '0;
      hist    <= '0;
      pol_ref <= 1'b0;
      fwin    <= '0;
    end else begin
      ev <= (ev & ~clr) | set;
      if (bit_en) begin
        hist    <= win_nxt;
        pol_ref <= pol_nxt;
        if (!bit_zero)    run_cnt <= '0;
        else if (run_inc) run_cnt <= run_cnt + 1'b1;
      end
      if (frm_bit_en) fwin <= fwin_nxt;
    end
  end

  assign rd_data = ev;

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(ev) & ~$past(clr)) & ~ev) == 6'h00));
  // R9
  fbe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_bit_en && frm_err) |=> rd_data[0]);
  // R9
  fbe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(frm_bit_en && frm_err) && !rd_data[0]) |=> !rd_data[0]);
  // R10
  cofa_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resync_done && resync_moved) |=> rd_data[5]);
  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[5] && resync_done && resync_moved) |=> rd_data[5]);
  // R4
  zero8_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !rd_data[4]) |=> !rd_data[4]);
  // R5
  zero16_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !rd_data[3]) |=> !rd_data[3]);
endmodule

// File: tb/t1_line_event_mon_tb.sv
module t1_line_event_mon_tb;
  logic clk = 0, rst_n = 0;
  logic bit_en = 0, rx_pos = 0, rx_neg = 0, frm_bit_en = 0, frm_err = 0;
  logic resync_done = 0, resync_moved = 0, wr_en = 0;
  logic [5:0] wr_data = 0;
  logic [5:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  t1_line_event_mon u_dut (.*);

  logic [5:0] m_ev = 0;
  int m_run = 0;
  int strm [0:8191];
  int sn = 0;
  bit fq [$];
  int last_pol = -1;

  function automatic int ref_pol(input int upto);
    for (int k = upto; k >= 0; k--) if (strm[k] != 0) return strm[k];
    return -1;
  endfunction

  function automatic bit is_codeword();
    int w0, p;
    if (sn < 8) return 0;
    w0 = sn - 8;
    p = ref_pol(w0 - 1);
    return strm[w0] == 0 && strm[w0+1] == 0 && strm[w0+2] == 0 &&
           strm[w0+3] == p && strm[w0+4] == -p && strm[w0+5] == 0 &&
           strm[w0+6] == -p && strm[w0+7] == p;
  endfunction

  function automatic int ones_q();
    int c = 0;
    foreach (fq[i]) c += fq[i];
    return c;
  endfunction

  task automatic cyc(input logic be, p, n, fe, ferr, rd, rm, we, input logic [5:0] wd);
    logic [5:0] s = 0;
    bit_en = be; rx_pos = p; rx_neg = n; frm_bit_en = fe; frm_err = ferr;
    resync_done = rd; resync_moved = rm; wr_en = we; wr_data = wd;
    if (be) begin
      strm[sn] = p ? 1 : (n ? -1 : 0);
      sn++;
      if (!p && !n) begin
        m_run++;
        if (m_run == 8) s[4] = 1;
        if (m_run == 16) s[3] = 1;
      end else m_run = 0;
      if (is_codeword()) s[1] = 1;
    end
    if (fe) begin
      fq.push_back(ferr);
      if (fq.size() > 6) void'(fq.pop_front());
      if (ones_q() >= 2) s[2] = 1;
      if (ferr) s[0] = 1;
    end
    if (rd && rm) s[5] = 1;
    m_ev = (m_ev & ~(we ? wd : 6'h00)) | s;
    @(negedge clk);
    bit_en = 0; rx_pos = 0; rx_neg = 0; frm_bit_en = 0; frm_err = 0;
    resync_done = 0; resync_moved = 0; wr_en = 0; wr_data = 0;
  endtask

  task automatic chk(input string tag, input logic [5:0] mask);
    checks++;
    if ((rd_data & mask) !== (m_ev & mask)) begin
      errors++;
      $display("FAIL %s got %b exp %b", tag, rd_data & mask, m_ev & mask);
    end
  endtask

  task automatic lbit(input int v);
    cyc(1, v > 0, v < 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic clear_all();
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 6'h3F);
  endtask
  task automatic fbit(input logic e);
    cyc(0, 0, 0, 1, e, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", 6'h3F);
    if (rd_data !== 6'h00) begin errors++; $display("FAIL R1 got %b exp 000000", rd_data); end
    checks++;

    // zero runs R4 R5 R6
    lbit(1);
    repeat (7) lbit(0);
    chk("R4", 6'h10);
    lbit(0);
    chk("R4", 6'h10);
    repeat (7) lbit(0);
    chk("R5", 6'h08);
    lbit(0);
    chk("R5", 6'h08);
    clear_all();
    repeat (20) lbit(0);
    chk("R6", 6'h18);
    lbit(-1);
    repeat (8) lbit(0);
    chk("R6", 6'h18);

    // R9
    clear_all();
    fbit(0);
    chk("R9", 6'h01);
    fbit(1);
    chk("R9", 6'h01);

    // R7
    repeat (6) fbit(0);
    clear_all();
    fbit(1); repeat (5) fbit(0); fbit(1);
    chk("R7", 6'h04);
    repeat (6) fbit(0);
    clear_all();
    fbit(1); repeat (4) fbit(0); fbit(1);
    chk("R7", 6'h04);

    // R8
    clear_all();
    lbit(-1);
    lbit(0); lbit(0); lbit(0); lbit(-1); lbit(1); lbit(0); lbit(1); lbit(-1);
    chk("R8", 6'h02);
    clear_all();
    lbit(1);
    lbit(0); lbit(0); lbit(0); lbit(-1); lbit(1); lbit(0); lbit(-1); lbit(1);
    chk("R8", 6'h02);

    // R10
    clear_all();
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R10", 6'h20);
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 0);
    chk("R10", 6'h20);

    // R2 partial clear, R11 collision
    cyc(0, 0, 0, 1, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 6'h01);
    chk("R2", 6'h3F);
    cyc(0, 0, 0, 1, 1, 0, 0, 1, 6'h21);
    chk("R11", 6'h3F);

    // random stream, R3 across all flags
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 100;
      logic fe = ($urandom % 8) == 0;
      logic fer = ($urandom % 4) == 0;
      logic rs = ($urandom % 50) == 0;
      logic rm = $urandom % 2;
      logic we = ($urandom % 10) == 0;
      logic [5:0] wd = 6'($urandom);
      if (r >= 97) begin
        int p = last_pol;
        int cw [8];
        cw = '{0, 0, 0, p, -p, 0, -p, p};
        for (int k = 0; k < 8; k++) begin
          cyc(1, cw[k] > 0, cw[k] < 0, 0, 0, 0, 0, 0, 0);
          chk("R8", 6'h3F);
        end
        continue;
      end
      if (r < 55) cyc(1, 0, 0, fe, fer, rs, rm, we, wd);
      else begin
        int v = (r < 92) ? -last_pol : last_pol;
        last_pol = v;
        cyc(1, v > 0, v < 0, fe, fer, rs, rm, we, wd);
      end
      chk("R3", 6'h3F);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule